// File: doc/BRIEF.md
# Free-Running Counter with Capture and Dual Compare

This block is a 16-bit up-counter that advances on every clock and never stops. Two compare registers watch it, and one capture register snapshots it when an external signal rises. Four sticky status flags record the events: capture, compare-A match, compare-B match, and counter wrap-around. A control bit lets a compare-A match restart the counter from zero, which turns the free-running counter into a programmable-period timebase.

Software reaches the block through a plain single-cycle register port: an address, a read strobe, a write strobe, write data and combinational read data. No data stream passes through the block. There is therefore no valid/ready pairing and no back-pressure: every access completes in the cycle it is presented, and the read data belongs to the address shown in that same cycle. The status flags can only be cleared by an interlocked sequence. Software must first read the status register while the flag is 1, and then write 0 to that flag. This stops a late event from being wiped out by a blind write.

Top module: `frt_unit`

## Requirements
- R1: After reset the counter and capture register read 0, both compare registers read 0xFFFF, and the status register (address 4) reads 0x00.
- R2: The counter (address 0) rises by one per clock. A write to address 0 loads the written value, and counting resumes from that value on the next clock.
- R3: Status bit 1 (wrap flag) becomes 1 on the clock where the counter goes from 0xFFFF to 0x0000, unless a software load happens in that same cycle.
- R4: Status bit 3 becomes 1 after a cycle in which the counter equals compare register A (address 1). Status bit 2 does the same for compare register B (address 2).
- R5: The capture input passes through a two-stage synchronizer and an edge detector. If the input is high at one clock edge, with the counter holding value V just before that edge, then three clocks later the capture register (address 3) holds V+2 and status bit 7 is 1.
- R6: Status bit 0 is the clear select. When it is 1, a compare-A match is followed by 0x0000, so the count runs ..., A, 0, 1. When it is 0, the match is followed by A+1.
- R7: A flag clears only when software writes 0 to its bit after a status read that saw that bit as 1. A write of 0 without such a read leaves the flag at 1.
- R8: A write of 1 to a flag bit never sets that flag. Status bits 6 to 4 always read 0, and writes to them have no effect.
- R9: If a hardware event for a flag arrives in the same cycle as a valid software clear of that flag, the flag stays 1.
- R10: The capture register is read-only. A write to address 3 leaves it unchanged.
- R11: A status read that sees a flag as 0 does not arm that flag. If the flag is set later, a write of 0 without a new read leaves it at 1.
- R12: Capture happens only on a rising edge. Holding the input high, or lowering it, causes no further capture and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Asynchronous capture request, acted on at its rising edge |
| bus_addr | input | 3 | Register select: 0 counter, 1 compare A, 2 compare B, 3 capture, 4 status/control |
| bus_rd | input | 1 | Read strobe; a read of address 4 arms the flags that read as 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data for the selected address, 0 when bus_rd is low |

## Verification
The bench builds the block with its defaults: a 16-bit counter and a two-stage synchronizer. Reaching the wrap point by counting alone would take 65,536 cycles. Instead, the bench loads values just below 0xFFFF, so wraps, wraps that collide with a status clear, and clear-on-match near the top of the range all happen within a few cycles. Because the synchronizer has two stages, the three-cycle capture latency is fixed. The bench can then predict the captured value exactly while the counter keeps running.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int NUM_CMP = 2;
  localparam int FLAG_N  = 4;

  // flag vector positions
  localparam int FI_OVF = 0;
  localparam int FI_CMB = 1;
  localparam int FI_CMA = 2;
  localparam int FI_CAP = 3;

  typedef enum logic [2:0] {
    RA_COUNT = 3'd0,
    RA_CMPA  = 3'd1,
    RA_CMPB  = 3'd2,
    RA_CAPT  = 3'd3,
    RA_STAT  = 3'd4
  } reg_addr_e;

  function automatic logic [2:0] cmp_addr(input int k);
    return 3'(int'(RA_CMPA) + k);
  endfunction

  // status byte: cap flag at 7, reserved 6..4, cmpA 3, cmpB 2, wrap 1, clear select 0
  function automatic logic [7:0] pack_status(input logic [FLAG_N-1:0] f,
                                             input logic clr_sel);
    return {f[FI_CAP], 3'b000, f[FI_CMA], f[FI_CMB], f[FI_OVF], clr_sel};
  endfunction

  function automatic logic [FLAG_N-1:0] flag_bits(input logic [7:0] d);
    logic [FLAG_N-1:0] r;
    r[FI_CAP] = d[7];
    r[FI_CMA] = d[3];
    r[FI_CMB] = d[2];
    r[FI_OVF] = d[1];
    return r;
  endfunction
endpackage

// File: rtl/frt_cap_sync.sv
module frt_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_in,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], cap_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int W       = 16,
  parameter int NUM_CMP = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld,
  input  logic [W-1:0]                ld_val,
  input  logic                        clr_on_a,
  input  logic [NUM_CMP-1:0][W-1:0]   ocr,
  output logic [W-1:0]                cnt_q,
  output logic [NUM_CMP-1:0]          match,
  output logic                        wrap
);
  logic [W-1:0] cnt_d;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign match[k] = (cnt_q == ocr[k]);
  end

  // the all-ones to zero step, whether by counting or by a clear on match
  assign wrap = (cnt_q == {W{1'b1}}) && !ld;

  always_comb begin
    if (ld)                        cnt_d = ld_val;
    else if (clr_on_a && match[0]) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frt_flags.sv
module frt_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         rd_stat,
  input  logic         wr_stat,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] arm_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clr;
    assign clr = wr_stat && arm_q[i] && !wr_bits[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        // hardware set outranks the software clear
        if (set_ev[i])  flag_q[i] <= 1'b1;
        else if (clr)   flag_q[i] <= 1'b0;

        if (clr)                        arm_q[i] <= 1'b0;
        else if (rd_stat && flag_q[i])  arm_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frt_unit.sv
module frt_unit
  import frt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic [2:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata
);
  logic [CNT_W-1:0]              cnt_q;
  logic [NUM_CMP-1:0][CNT_W-1:0] ocr_q;
  logic [CNT_W-1:0]              icr_q;
  logic                          cclr_q;
  logic [NUM_CMP-1:0]            cmp_hit;
  logic                          cnt_wrap;
  logic                          cap_rise;
  logic [FLAG_N-1:0]             set_ev;
  logic [FLAG_N-1:0]             flag_q;
  logic                          cnt_ld;
  logic                          stat_wr;
  logic                          stat_rd;
  logic [NUM_CMP-1:0]            ocr_wr;

  assign cnt_ld  = bus_wr && (bus_addr == RA_COUNT);
  assign stat_wr = bus_wr && (bus_addr == RA_STAT);
  assign stat_rd = bus_rd && (bus_addr == RA_STAT);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_ocr_dec
    assign ocr_wr[k] = bus_wr && (bus_addr == cmp_addr(k));
  end

  frt_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_in (cap_in),
    .rise   (cap_rise)
  );

  frt_counter #(.W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (cnt_ld),
    .ld_val   (bus_wdata),
    .clr_on_a (cclr_q),
    .ocr      (ocr_q),
    .cnt_q    (cnt_q),
    .match    (cmp_hit),
    .wrap     (cnt_wrap)
  );

  assign set_ev[FI_CAP] = cap_rise;
  assign set_ev[FI_CMA] = cmp_hit[0];
  assign set_ev[FI_CMB] = cmp_hit[1];
  assign set_ev[FI_OVF] = cnt_wrap;

  frt_flags #(.N(FLAG_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .rd_stat (stat_rd),
    .wr_stat (stat_wr),
    .wr_bits (flag_bits(bus_wdata[7:0])),
    .flag_q  (flag_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocr_q  <= '1;
      icr_q  <= '0;
      cclr_q <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_CMP; k++) begin
        if (ocr_wr[k]) ocr_q[k] <= bus_wdata;
      end
      if (cap_rise) icr_q  <= cnt_q;
      if (stat_wr)  cclr_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        RA_COUNT: bus_rdata = cnt_q;
        RA_CMPA:  bus_rdata = ocr_q[0];
        RA_CMPB:  bus_rdata = ocr_q[1];
        RA_CAPT:  bus_rdata = icr_q;
        RA_STAT:  bus_rdata = CNT_W'(pack_status(flag_q, cclr_q));
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/frt_unit_chk.sv
module frt_unit_chk
  import frt_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      cnt_q,
  input logic [W-1:0]      ocra,
  input logic              cclr,
  input logic              cnt_ld,
  input logic [FLAG_N-1:0] set_ev,
  input logic [FLAG_N-1:0] flags,
  input logic              stat_wr,
  input logic [2:0]        bus_addr,
  input logic              bus_rd,
  input logic [W-1:0]      bus_rdata
);
  logic [W-1:0] cnt_inc;
  assign cnt_inc = cnt_q + 1'b1;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ld && !(cclr && cnt_q == ocra)) |=> cnt_q == $past(cnt_inc));

  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {W{1'b1}} && !cnt_ld) |=> flags[FI_OVF]);

  assert_cmpa_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == ocra) |=> flags[FI_CMA]);

  assert_clear_on_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cclr && cnt_q == ocra && !cnt_ld) |=> cnt_q == '0);

  assert_fall_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((~flags & $past(flags)) == '0));

  assert_no_sw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flags & ~$past(flags) & ~$past(set_ev)) == '0));

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4) |-> bus_rdata[6:4] == 3'b000);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~flags & $past(set_ev)) == '0));
endmodule

bind frt_unit frt_unit_chk #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_q     (cnt_q),
  .ocra      (ocr_q[0]),
  .cclr      (cclr_q),
  .cnt_ld    (cnt_ld),
  .set_ev    (set_ev),
  .flags     (flag_q),
  .stat_wr   (stat_wr),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata)
);

// File: tb/frt_unit_test.sv
module frt_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CNT = 3'd0, A_CPA = 3'd1, A_CPB = 3'd2,
                         A_CAP = 3'd3, A_STS = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;

  frt_unit uut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---- reference model, built from the requirements ----
  logic [15:0] m_cnt, m_icr;
  logic [15:0] m_ocr [2];
  logic        m_cclr;
  logic [3:0]  m_flg, m_arm;   // [3]=cap [2]=cmpA [1]=cmpB [0]=wrap
  logic [2:0]  m_sy;

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      A_CNT:   return m_cnt;
      A_CPA:   return m_ocr[0];
      A_CPB:   return m_ocr[1];
      A_CAP:   return m_icr;
      A_STS:   return {8'h00, m_flg[3], 3'b000, m_flg[2], m_flg[1], m_flg[0], m_cclr};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_icr = 0; m_ocr[0] = 16'hFFFF; m_ocr[1] = 16'hFFFF;
    m_cclr = 0; m_flg = 0; m_arm = 0; m_sy = 0;
  endtask

  task automatic model_step(input logic [2:0] a, input logic r, input logic w,
                            input logic [15:0] d, input logic cin);
    logic       rise, ma, mb, ld, swr;
    logic [3:0] ev, wb;
    rise = m_sy[1] & ~m_sy[2];
    ma = (m_cnt == m_ocr[0]);
    mb = (m_cnt == m_ocr[1]);
    ld = w && a == A_CNT;
    swr = w && a == A_STS;
    ev = {rise, ma, mb, (m_cnt == 16'hFFFF) && !ld};
    wb = {d[7], d[3], d[2], d[1]};
    if (rise) m_icr = m_cnt;
    for (int i = 0; i < 4; i++) begin
      logic c;
      c = swr && m_arm[i] && !wb[i];
      if (c) m_arm[i] = 1'b0;
      else if (r && a == A_STS && m_flg[i]) m_arm[i] = 1'b1;
      if (ev[i]) m_flg[i] = 1'b1;
      else if (c) m_flg[i] = 1'b0;
    end
    if (ld) m_cnt = d;
    else if (m_cclr && ma) m_cnt = 16'h0000;
    else m_cnt = m_cnt + 16'd1;
    if (w && a == A_CPA) m_ocr[0] = d;
    if (w && a == A_CPB) m_ocr[1] = d;
    if (swr) m_cclr = d[0];
    m_sy = {m_sy[1:0], cin};
  endtask

  // ---- bus access and checking ----
  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] a, input logic r, input logic w,
                    input logic [15:0] d, output logic [15:0] q);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    #1;
    q = bus_rdata;
    @(posedge clk);
    model_step(a, r, w, d, cap_in);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    logic [15:0] q;
    op(a, 1'b0, 1'b1, d, q);
  endtask

  task automatic idle(input int n);
    logic [15:0] q;
    for (int i = 0; i < n; i++) op(3'd0, 1'b0, 1'b0, 16'h0, q);
  endtask

  // read, compared against the model and against a literal from the requirement
  task automatic rdl(input logic [2:0] a, input string req, input logic [15:0] lit);
    logic [15:0] e, q;
    e = exp_read(a);
    op(a, 1'b1, 1'b0, 16'h0, q);
    check(req, q, e);
    check(req, q, lit);
  endtask

  task automatic rdm(input logic [2:0] a, input string req);
    logic [15:0] e, q;
    e = exp_read(a);
    op(a, 1'b1, 1'b0, 16'h0, q);
    check(req, q, e);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rdm(A_CNT, "R1");
    rdl(A_CPA, "R1", 16'hFFFF);
    rdl(A_CPB, "R1", 16'hFFFF);
    rdl(A_CAP, "R1", 16'h0000);
    rdl(A_STS, "R1", 16'h0000);

    // R2 load and count
    wr(A_CNT, 16'h1234);
    rdl(A_CNT, "R2", 16'h1234);
    rdl(A_CNT, "R2", 16'h1235);

    // R6 clear on compare A enabled
    wr(A_CPA, 16'h0040);
    wr(A_STS, 16'h0001);
    wr(A_CNT, 16'h003E);
    rdl(A_CNT, "R6", 16'h003E);
    rdl(A_CNT, "R6", 16'h003F);
    rdl(A_CNT, "R6", 16'h0040);
    rdl(A_CNT, "R6", 16'h0000);
    rdl(A_CNT, "R6", 16'h0001);
    rdl(A_STS, "R4", 16'h0009);      // cmpA flag plus clear select, arms cmpA
    wr(A_STS, 16'h0001);             // R7 armed clear
    rdl(A_STS, "R7", 16'h0001);

    // R6 clear select off: count runs past the match
    wr(A_STS, 16'h0000);
    wr(A_CNT, 16'h003F);
    rdl(A_CNT, "R6", 16'h003F);
    rdl(A_CNT, "R6", 16'h0040);
    rdl(A_CNT, "R6", 16'h0041);
    wr(A_STS, 16'h0000);             // R7 write without read
    rdl(A_STS, "R7", 16'h0008);
    wr(A_STS, 16'h0000);
    rdl(A_STS, "R7", 16'h0000);

    // R8 writing ones sets nothing, reserved bits read 0
    wr(A_STS, 16'h00FE);
    rdl(A_STS, "R8", 16'h0000);

    // R4 compare B
    wr(A_CPB, 16'h0100);
    wr(A_CNT, 16'h00FE);
    idle(3);
    rdl(A_STS, "R4", 16'h0004);
    wr(A_STS, 16'h0000);

    // R5 capture latency and value
    wr(A_CNT, 16'h0200);
    cap_in = 1'b1;
    idle(3);
    rdl(A_CAP, "R5", 16'h0202);
    rdl(A_STS, "R5", 16'h0080);

    // R12 level held and falling edge do nothing
    wr(A_STS, 16'h0000);
    idle(8);
    rdl(A_STS, "R12", 16'h0000);
    rdl(A_CAP, "R12", 16'h0202);
    cap_in = 1'b0;
    idle(5);
    rdl(A_STS, "R12", 16'h0000);

    // R10 capture register read-only
    wr(A_CAP, 16'h5555);
    rdl(A_CAP, "R10", 16'h0202);

    // R3 wrap flag
    wr(A_CNT, 16'hFFFE);
    idle(2);
    rdl(A_STS, "R3", 16'h0002);
    // R9 clear collides with a new wrap
    wr(A_CNT, 16'hFFFE);
    idle(1);
    wr(A_STS, 16'h0000);
    rdl(A_STS, "R9", 16'h0002);
    wr(A_STS, 16'h0000);
    rdl(A_STS, "R9", 16'h0000);      // flag reads 0: must not arm (R11)
    // R11 stale read does not arm
    wr(A_CNT, 16'hFFFE);
    idle(2);
    wr(A_STS, 16'h0000);
    rdl(A_STS, "R11", 16'h0002);
    wr(A_STS, 16'h0000);
    rdl(A_STS, "R11", 16'h0000);

    // constrained random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [15:0] d;
      sel = $urandom_range(0, 99);
      if ($urandom_range(0, 9) == 0) cap_in = ~cap_in;
      if (sel < 35) idle(1);
      else if (sel < 55) rdm(A_STS, "R7");
      else if (sel < 65) begin
        d = 16'($urandom_range(0, 255));
        wr(A_STS, d);
      end else if (sel < 72) begin
        d = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(16'hFFE0, 16'hFFFF))
                                        : 16'($urandom);
        wr(A_CNT, d);
      end else if (sel < 80) begin
        d = m_cnt + 16'($urandom_range(1, 40));
        wr(($urandom_range(0, 1) == 1) ? A_CPA : A_CPB, d);
      end else if (sel < 88) rdm(A_CNT, "R2");
      else if (sel < 93) rdm(A_CAP, "R5");
      else if (sel < 97) rdm(($urandom_range(0, 1) == 1) ? A_CPA : A_CPB, "R4");
      else wr(A_CAP, 16'($urandom));
    end

    finish_run();
  end
endmodule